// File: doc/BRIEF.md
# Interrupt acceptance unit

This unit decides when a small 8-bit processor core leaves its instruction stream to service an interrupt. It watches two asynchronous request pins. The maskable pin is active-low and level-sensitive, and several devices may share it. The non-maskable pin is active-low and edge-sensitive. The unit also owns the interrupt-disable flag. Each pin first passes through a synchronizer. The unit then evaluates the requests whenever the execution unit reports an instruction boundary.

When the unit accepts a request, it raises `int_start` for one cycle together with a vector select. The vector select is 0 for the maskable vector and 1 for the non-maskable vector. The execution unit treats `int_start` as the start of its stacking and vector-fetch sequence. The same cycle sets the disable flag and acknowledges a latched non-maskable edge.

The execution unit sends the following to the unit:
- strobes from the set-disable and clear-disable instructions;
- a strobe from return-from-interrupt, together with the flag value it pulled off the stack.

A maskable line that stays low therefore re-enters service as soon as the flag drops. A non-maskable line that stays low fires only once.

Top module: `irq_accept_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `disable_flag` equals the `RESET_DISABLE` parameter (default 1), no edge is pending and `int_start` is 0.
- R2: A maskable request is accepted (`int_start`=1, `int_vec_nmi`=0) only while `insn_boundary` is 1, the synchronized `irq_n` is 0 and `disable_flag` is 0.
- R3: The clock edge that ends a cycle with `int_start`=1 sets `disable_flag` to 1.
- R4: When no entry occurs, the flag is updated in this priority order: `cmd_rti` loads `rti_disable_value`, then `cmd_set_disable` sets the flag, then `cmd_clear_disable` clears it. With no strobe, the flag holds its value.
- R5: If `irq_n` is still low when the flag is cleared, by return-from-interrupt or by clear-disable, a new maskable entry starts at the next boundary.
- R6: A high-to-low transition of the synchronized `nmi_n` produces an entry with `int_vec_nmi`=1, regardless of `disable_flag`.
- R7: Holding `nmi_n` low yields exactly one non-maskable entry. A further entry needs the pin to return high and fall again.
- R8: A detected non-maskable edge stays latched until an entry takes it, so a low pulse lasting one clock is serviced at a later boundary.
- R9: If a latched non-maskable edge and an eligible maskable request meet at the same boundary, the non-maskable one wins and the maskable one stays pending.
- R10: With `SYNC_STAGES`=2, a low on `irq_n` can raise `int_start` after the second rising edge at the earliest. A falling edge on `nmi_n` can do so after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Shared maskable request, active low, level-sensitive |
| nmi_n | input | 1 | Non-maskable request, active low, falling-edge triggered |
| insn_boundary | input | 1 | High in a cycle where an interrupt may begin |
| cmd_set_disable | input | 1 | Set-disable instruction strobe |
| cmd_clear_disable | input | 1 | Clear-disable instruction strobe |
| cmd_rti | input | 1 | Return-from-interrupt flag restore strobe |
| rti_disable_value | input | 1 | Flag value restored by `cmd_rti` |
| int_start | output | 1 | One-cycle start of an interrupt entry sequence |
| int_vec_nmi | output | 1 | Vector select: 1 non-maskable, 0 maskable; valid with `int_start` |
| disable_flag | output | 1 | Current interrupt-disable flag |

## Verification
The assertions take for granted that the flag strobes come from the execution unit as single-cycle pulses. They also assume the execution unit never drops an `int_start` it was handed, so that every accepted entry is followed by the flag set. In directed phases the stimulus asserts at most one flag strobe per cycle, except where the R4 priority is being probed. In the random phase the stimulus holds each pin level for at least one clock, so every transition passes the synchronizer. Whether `int_start` may appear during a cycle that also carries a strobe is left to the reference model, which applies the entry-first priority.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

   typedef enum logic {
      VEC_MASKABLE = 1'b0,
      VEC_NONMASK  = 1'b1
   } vec_sel_e;

   typedef struct packed {
      logic rti;
      logic rti_val;
      logic set_dis;
      logic clr_dis;
   } flag_cmd_t;

endpackage

// File: rtl/iau_sync_chain.sv
module iau_sync_chain #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("iau_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] stage_q;

   generate
      for (genvar i = 0; i <= LAST; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[i] <= RST_VAL;
               else        stage_q[i] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[i] <= RST_VAL;
               else        stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[LAST];
endmodule

// File: rtl/iau_nmi_edge_latch.sv
module iau_nmi_edge_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_sync_n,
   input  logic take,
   output logic pending
);
   logic prev_q;
   logic pend_q;
   logic fall;

   assign fall = prev_q & ~nmi_sync_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         prev_q <= nmi_sync_n;
         pend_q <= fall | (pend_q & ~take);
      end
   end

   assign pending = pend_q;

   // R8: an untaken edge stays latched
   a_r8_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !take |=> pend_q);

   // R7: a taken edge is gone unless the line produced a new fall
   a_r7_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && take && !fall |=> !pend_q);

   // R7: a line that stays low raises no new request
   a_r7_low_no_new: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q && !nmi_sync_n && !prev_q |=> !pend_q);
endmodule

// File: rtl/iau_disable_flag.sv
module iau_disable_flag
   import irq_accept_pkg::*;
#(
   parameter logic RESET_DISABLE = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      entry,
   input  flag_cmd_t cmd,
   output logic      flag
);
   logic flag_q;
   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      if (entry)            flag_d = 1'b1;
      else if (cmd.rti)     flag_d = cmd.rti_val;
      else if (cmd.set_dis) flag_d = 1'b1;
      else if (cmd.clr_dis) flag_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= RESET_DISABLE;
      else        flag_q <= flag_d;
   end

   assign flag = flag_q;

   a_r3_entry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> flag_q);

   a_r4_rti_restores: assert property (@(posedge clk) disable iff (!rst_n)
      !entry && cmd.rti |=> flag_q == $past(cmd.rti_val));

   a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      !entry && !cmd.rti && !cmd.set_dis && cmd.clr_dis |=> !flag_q);

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !entry && !cmd.rti && !cmd.set_dis && !cmd.clr_dis |=> $stable(flag_q));
endmodule

// File: rtl/iau_arbiter.sv
module iau_arbiter
   import irq_accept_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     boundary,
   input  logic     nmi_pending,
   input  logic     irq_sync_n,
   input  logic     disable_flag,
   output logic     start,
   output vec_sel_e vec,
   output logic     take_nmi
);
   logic irq_eligible;

   assign irq_eligible = ~irq_sync_n & ~disable_flag;

   always_comb begin
      start    = 1'b0;
      vec      = VEC_MASKABLE;
      take_nmi = 1'b0;
      if (boundary) begin
         if (nmi_pending) begin
            start    = 1'b1;
            vec      = VEC_NONMASK;
            take_nmi = 1'b1;
         end else if (irq_eligible) begin
            start = 1'b1;
         end
      end
   end

   a_r2_masked_entry_legal: assert property (@(posedge clk) disable iff (!rst_n)
      start && vec == VEC_MASKABLE |-> !disable_flag && !irq_sync_n && boundary);

   a_r9_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
      boundary && nmi_pending |-> start && vec == VEC_NONMASK);

   a_r6_nmi_ignores_mask: assert property (@(posedge clk) disable iff (!rst_n)
      boundary && nmi_pending && disable_flag |-> start);
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
   import irq_accept_pkg::*;
#(
   parameter int   SYNC_STAGES   = 2,
   parameter logic RESET_DISABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_n,
   input  logic nmi_n,
   input  logic insn_boundary,
   input  logic cmd_set_disable,
   input  logic cmd_clear_disable,
   input  logic cmd_rti,
   input  logic rti_disable_value,
   output logic int_start,
   output logic int_vec_nmi,
   output logic disable_flag
);
   logic      irq_sync_n;
   logic      nmi_sync_n;
   logic      nmi_pend;
   logic      take_nmi;
   logic      start;
   vec_sel_e  vec;
   flag_cmd_t cmd;
   logic      flag;

   iau_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_irq (
      .clk(clk), .rst_n(rst_n), .d_async(irq_n), .q_sync(irq_sync_n));

   iau_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_nmi (
      .clk(clk), .rst_n(rst_n), .d_async(nmi_n), .q_sync(nmi_sync_n));

   iau_nmi_edge_latch i_edge (
      .clk(clk), .rst_n(rst_n), .nmi_sync_n(nmi_sync_n),
      .take(take_nmi), .pending(nmi_pend));

   iau_arbiter i_arb (
      .clk(clk), .rst_n(rst_n), .boundary(insn_boundary),
      .nmi_pending(nmi_pend), .irq_sync_n(irq_sync_n),
      .disable_flag(flag), .start(start), .vec(vec), .take_nmi(take_nmi));

   assign cmd = '{rti: cmd_rti, rti_val: rti_disable_value,
                  set_dis: cmd_set_disable, clr_dis: cmd_clear_disable};

   iau_disable_flag #(.RESET_DISABLE(RESET_DISABLE)) i_flag (
      .clk(clk), .rst_n(rst_n), .entry(start), .cmd(cmd), .flag(flag));

   assign int_start    = start;
   assign int_vec_nmi  = (vec == VEC_NONMASK);
   assign disable_flag = flag;

   // R5: a held maskable line re-enters once the mask is down
   a_r5_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      insn_boundary && !flag && !irq_sync_n |-> int_start);

   // R2: no entry outside a boundary
   a_r2_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_boundary |-> !int_start);
endmodule

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_n = 1'b1, nmi_n = 1'b1, insn_boundary = 1'b0;
   logic cmd_set_disable = 1'b0, cmd_clear_disable = 1'b0;
   logic cmd_rti = 1'b0, rti_disable_value = 1'b0;
   logic int_start, int_vec_nmi, disable_flag;

   always #10 clk = ~clk;

   irq_accept_unit #(.SYNC_STAGES(SYNC), .RESET_DISABLE(1'b1)) i_irq_accept_unit (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
      .insn_boundary(insn_boundary), .cmd_set_disable(cmd_set_disable),
      .cmd_clear_disable(cmd_clear_disable), .cmd_rti(cmd_rti),
      .rti_disable_value(rti_disable_value), .int_start(int_start),
      .int_vec_nmi(int_vec_nmi), .disable_flag(disable_flag));

   int compared = 0, mismatched = 0;
   int nmi_seen = 0, irq_seen = 0;
   bit started = 0, finished = 0;
   string cur_req = "R1";

   // reference model state
   bit q_irq[$], q_nmi[$];
   bit m_prev = 1, m_pend = 0, m_flag = 1;

   initial begin
      for (int i = 0; i < SYNC; i++) begin
         q_irq.push_back(1'b1);
         q_nmi.push_back(1'b1);
      end
   end

   function automatic bit exp_start();
      return insn_boundary && (m_pend || (!q_irq[0] && !m_flag));
   endfunction

   always @(posedge clk) begin
      bit st, fall;
      started = 1;
      if (!rst_n) begin
         m_prev = 1; m_pend = 0; m_flag = 1;
         for (int i = 0; i < SYNC; i++) begin q_irq[i] = 1; q_nmi[i] = 1; end
      end else begin
         st   = exp_start();
         fall = m_prev && !q_nmi[0];
         if (st)                     m_flag = 1;
         else if (cmd_rti)           m_flag = rti_disable_value;
         else if (cmd_set_disable)   m_flag = 1;
         else if (cmd_clear_disable) m_flag = 0;
         m_pend = fall || (m_pend && !(st && m_pend));
         m_prev = q_nmi[0];
         void'(q_irq.pop_front()); q_irq.push_back(irq_n);
         void'(q_nmi.pop_front()); q_nmi.push_back(nmi_n);
      end
   end

   task automatic chk(string tag, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && !finished) begin
         chk({cur_req, " flag"}, disable_flag, m_flag);
         chk({cur_req, " start"}, int_start, exp_start());
         if (int_start && exp_start()) chk({cur_req, " vector"}, int_vec_nmi, m_pend);
         if (int_start && int_vec_nmi) nmi_seen++;
         if (int_start && !int_vec_nmi) irq_seen++;
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int base;
      tick(3);
      chk("R1 reset flag", disable_flag, 1);
      chk("R1 reset start", int_start, 0);
      rst_n = 1;
      tick(2);

      cur_req = "R2";
      insn_boundary = 1; irq_n = 0; base = irq_seen;
      tick(6);
      chk("R2 masked while flag set", irq_seen - base, 0);
      cmd_clear_disable = 1; tick(1); cmd_clear_disable = 0;
      tick(2);
      chk("R2 accepted once flag clear", irq_seen - base, 1);
      cur_req = "R3";
      chk("R3 flag set by entry", disable_flag, 1);

      cur_req = "R5";
      base = irq_seen;
      cmd_rti = 1; rti_disable_value = 0; tick(1); cmd_rti = 0;
      tick(2);
      chk("R5 reentry after restore", irq_seen - base, 1);
      irq_n = 1; tick(3);

      cur_req = "R4";
      insn_boundary = 0;
      cmd_set_disable = 1; cmd_clear_disable = 1; tick(1);
      chk("R4 set beats clear", disable_flag, 1);
      cmd_set_disable = 0; tick(1);
      chk("R4 clear alone", disable_flag, 0);
      cmd_clear_disable = 1; cmd_rti = 1; rti_disable_value = 1; tick(1);
      chk("R4 rti beats clear", disable_flag, 1);
      cmd_clear_disable = 0; cmd_set_disable = 1; rti_disable_value = 0; tick(1);
      chk("R4 rti beats set", disable_flag, 0);
      cmd_set_disable = 0; cmd_rti = 0; tick(2);
      chk("R4 hold", disable_flag, 0);

      cur_req = "R10";
      insn_boundary = 1; irq_n = 0; tick(1);
      chk("R10 not after one edge", int_start, 0);
      tick(1);
      chk("R10 start after second edge", int_start, 1);
      irq_n = 1; tick(4);

      cur_req = "R6";
      base = nmi_seen;
      nmi_n = 0; tick(1);
      chk("R6 no start before edge detect", int_start, 0);
      tick(1);
      chk("R6 no start after second edge", int_start, 0);
      tick(1);
      chk("R6 start after third edge", int_start, 1);
      chk("R6 vector nmi", int_vec_nmi, 1);
      tick(2);
      chk("R6 entry with flag set", nmi_seen - base, 1);

      cur_req = "R7";
      tick(20);
      chk("R7 held low fires once", nmi_seen - base, 1);
      nmi_n = 1; tick(4); nmi_n = 0; tick(5);
      chk("R7 new fall fires again", nmi_seen - base, 2);
      nmi_n = 1; tick(4);

      cur_req = "R8";
      insn_boundary = 0; base = nmi_seen;
      nmi_n = 0; tick(1); nmi_n = 1; tick(10);
      chk("R8 no entry without boundary", nmi_seen - base, 0);
      insn_boundary = 1; #1;
      chk("R8 latched edge taken", int_start, 1);
      chk("R8 vector", int_vec_nmi, 1);
      tick(1); insn_boundary = 0;

      cur_req = "R9";
      cmd_clear_disable = 1; tick(1); cmd_clear_disable = 0;
      irq_n = 0; nmi_n = 0; tick(1); nmi_n = 1; tick(4);
      insn_boundary = 1; #1;
      chk("R9 nmi wins", int_vec_nmi, 1);
      base = irq_seen;
      tick(1);
      chk("R9 irq masked after nmi entry", int_start, 0);
      cmd_clear_disable = 1; tick(1); cmd_clear_disable = 0; tick(1);
      chk("R9 irq serviced afterwards", irq_seen - base, 1);
      irq_n = 1; insn_boundary = 0; tick(3);

      cur_req = "RAND";
      for (int i = 0; i < 600; i++) begin
         insn_boundary = ($urandom % 3) == 0;
         if (($urandom % 6) == 0) irq_n = ~irq_n;
         if (($urandom % 7) == 0) nmi_n = ~nmi_n;
         cmd_set_disable = 0; cmd_clear_disable = 0; cmd_rti = 0;
         case ($urandom % 10)
            0: cmd_set_disable = 1;
            1: cmd_clear_disable = 1;
            2: begin cmd_rti = 1; rti_disable_value = $urandom % 2; end
            3: begin cmd_clear_disable = 1; cmd_set_disable = $urandom % 2; end
            default: ;
         endcase
         tick(1);
      end
      tick(2);
      finish_run();
   end
endmodule